// File: doc/BRIEF.md
# Virtual Deadline Task Scheduler

This block is a hardware dispatcher for a small set of periodic real-time tasks under fixed-priority preemptive scheduling. Each task slot carries a static priority, a period, a relative deadline and the release time of its current job, and sits in one of three states: running, ready or dormant. Whenever software signals a scheduler tick or the completion of the running job, the block releases every dormant task whose release time has come, dispatches or preempts by priority, and registers a new set of outputs one cycle later.

Beyond plain dispatch, the block tells the running task how much time it may stretch over. When no other task is ready, the running task gets a virtual deadline: the earlier of its own absolute deadline and the next release among dormant tasks. When another task is waiting, the running task is flagged to finish within its worst-case time. When nothing can run, the block raises a power-down request and reports the wake-up time of the earliest dormant task. A free-running time counter supplies the time base. Software loads each slot through a small write port.

Top module: `vdl_sched`

## Requirements
- R1: At most one task is running at any time; `run_valid` is 1 exactly when a task runs and `run_idx` then names it.
- R2: On an event (`tick` or `done`), every loaded dormant task whose release time is less than or equal to the current `cur_time` becomes ready; a dormant task whose release time lies in the future stays dormant.
- R3: Among ready tasks the one with the smallest priority value wins; among equal priority values the lower task index wins.
- R4: A ready task preempts the running task only if its priority value is strictly smaller; the preempted task becomes ready. Equal priority never preempts.
- R5: `done` moves the running task to dormant and advances its release time by its period; `done` with no task running changes nothing.
- R6: When a task runs and no other task is ready, `mode_forced` is 0 and `vdeadline` is the minimum of the task's absolute deadline (release time plus relative deadline) and the earliest release time among dormant tasks.
- R7: When a task runs while at least one other task is ready, `mode_forced` is 1 and `vdeadline` is the running task's own absolute deadline.
- R8: When no task runs after an event, `power_down` is 1, `run_valid` is 0, and `wake_time` is the earliest release time among dormant tasks.
- R9: `cur_time` counts up by one per clock from 0 after reset; the scheduling outputs change only on the clock edge that samples an event and hold otherwise.
- R10: A write with `cfg_we` loads slot `cfg_idx` with priority, period, relative deadline and first release time and makes it dormant; after reset no slot is loaded and all scheduling outputs are 0.
- R11: When no task runs and no slot is dormant, `wake_time` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load one task slot |
| cfg_idx | input | IW | Slot to load |
| cfg_prio | input | PW | Static priority, smaller is more urgent |
| cfg_period | input | TW | Period |
| cfg_rdl | input | TW | Relative deadline |
| cfg_rel | input | TW | First release time |
| tick | input | 1 | Scheduler invocation |
| done | input | 1 | Running job completed |
| cur_time | output | TW | Free-running time counter |
| run_valid | output | 1 | A task is running |
| run_idx | output | IW | Running task index |
| mode_forced | output | 1 | 1: finish within worst-case time, 0: virtual deadline applies |
| vdeadline | output | TW | Deadline handed to the running task |
| power_down | output | 1 | Nothing runnable, power-down requested |
| wake_time | output | TW | Earliest dormant release time |

## Verification
The bench walks one task set through release, preemption, completion and idle phases, computing each expected deadline from the configured fields. It targets the virtual deadline clipped by a dormant release versus left at the task's own deadline, which a design that ignored the dormant set or compared the wrong way would get wrong by hundreds of time units. It checks that equal priority does not preempt and that ties go to the lower index, which a design using a non-strict compare or a high-index-first search would break, and that a completion advances the release by exactly one period, visible later in `wake_time`. A completion while idle and the empty task set with its all-ones wake time are also exercised.

// File: rtl/vds_pkg.sv
package vds_pkg;
  parameter int VDS_TASKS = 8;
  parameter int VDS_TW    = 16;
  parameter int VDS_PW    = 3;

  typedef enum logic [1:0] {
    ST_DORM  = 2'd0,
    ST_READY = 2'd1,
    ST_RUN   = 2'd2
  } tstate_e;
endpackage

// File: rtl/vds_timebase.sv
module vds_timebase #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [TW-1:0] now
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now <= '0;
    else        now <= now + TW'(1);
  end
endmodule

// File: rtl/vds_argmin.sv
module vds_argmin #(
  parameter int N  = 8,
  parameter int KW = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vld,
  input  logic [KW-1:0] key [N],
  output logic          any,
  output logic [IW-1:0] idx,
  output logic [KW-1:0] kmin
);
  // strict less-than: the earliest index keeps a tie
  function automatic logic beats(input logic [KW-1:0] a, input logic [KW-1:0] b);
    return a < b;
  endfunction

  always_comb begin
    any  = 1'b0;
    idx  = '0;
    kmin = '1;
    for (int i = 0; i < N; i++) begin
      if (vld[i] && (!any || beats(key[i], kmin))) begin
        any  = 1'b1;
        idx  = IW'(i);
        kmin = key[i];
      end
    end
  end
endmodule

// File: rtl/vds_task_slot.sv
module vds_task_slot
  import vds_pkg::*;
#(
  parameter int TW = 16,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] ld_prio,
  input  logic [TW-1:0] ld_period,
  input  logic [TW-1:0] ld_rdl,
  input  logic [TW-1:0] ld_rel,
  input  logic [TW-1:0] now,
  input  logic          complete,
  input  logic          upd,
  input  tstate_e       nxt_state,
  output logic          en,
  output tstate_e       state,
  output logic [PW-1:0] prio,
  output logic [TW-1:0] rel_nx,
  output logic [TW-1:0] dl_nx,
  output logic          due
);
  logic [TW-1:0] period_q, rdl_q, rel_q;

  function automatic logic [TW-1:0] advance(input logic [TW-1:0] r, input logic [TW-1:0] p,
                                            input logic go);
    return go ? r + p : r;
  endfunction

  function automatic logic reached(input logic [TW-1:0] r, input logic [TW-1:0] t);
    return r <= t;
  endfunction

  assign rel_nx = advance(rel_q, period_q, complete);
  assign dl_nx  = rel_nx + rdl_q;
  assign due    = en && (complete || state == ST_DORM) && reached(rel_nx, now);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en       <= 1'b0;
      state    <= ST_DORM;
      prio     <= '0;
      period_q <= '0;
      rdl_q    <= '0;
      rel_q    <= '0;
    end else if (load) begin
      en       <= 1'b1;
      state    <= ST_DORM;
      prio     <= ld_prio;
      period_q <= ld_period;
      rdl_q    <= ld_rdl;
      rel_q    <= ld_rel;
    end else if (upd && en) begin
      state    <= nxt_state;
      rel_q    <= rel_nx;
    end
  end
endmodule

// File: rtl/vdl_sched.sv
module vdl_sched
  import vds_pkg::*;
#(
  parameter int NTASK = VDS_TASKS,
  parameter int TW    = VDS_TW,
  parameter int PW    = VDS_PW,
  localparam int IW   = (NTASK > 1) ? $clog2(NTASK) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_idx,
  input  logic [PW-1:0] cfg_prio,
  input  logic [TW-1:0] cfg_period,
  input  logic [TW-1:0] cfg_rdl,
  input  logic [TW-1:0] cfg_rel,
  input  logic          tick,
  input  logic          done,
  output logic [TW-1:0] cur_time,
  output logic          run_valid,
  output logic [IW-1:0] run_idx,
  output logic          mode_forced,
  output logic [TW-1:0] vdeadline,
  output logic          power_down,
  output logic [TW-1:0] wake_time
);
  // ---------------- named internal events ----------------
  logic                ev;
  logic [NTASK-1:0]    run_mask;     // slots currently in RUN
  logic [NTASK-1:0]    complete_v;   // running slot finishing now
  logic [NTASK-1:0]    keep_v;       // running slot that carries on
  logic [NTASK-1:0]    rdy_v;        // ready after releases
  logic [NTASK-1:0]    dorm_v;       // dormant after this event
  logic [NTASK-1:0]    others_v;     // ready but not chosen after dispatch
  logic                keep_any;
  logic [PW-1:0]       keep_prio;
  logic [IW-1:0]       keep_idx;
  logic                best_any;
  logic [IW-1:0]       best_idx;
  logic [PW-1:0]       best_prio;
  logic                preempt;
  logic                dispatch;
  logic                new_valid;
  logic [IW-1:0]       new_idx;
  logic                others_ready;
  logic                dmin_any;
  logic [IW-1:0]       dmin_idx;
  logic [TW-1:0]       dmin_rel;
  logic [TW-1:0]       run_dl;
  logic [TW-1:0]       vd_next;

  logic                en_a    [NTASK];
  tstate_e             st_a    [NTASK];
  tstate_e             nxt_a   [NTASK];
  logic [PW-1:0]       prio_a  [NTASK];
  logic [TW-1:0]       reln_a  [NTASK];
  logic [TW-1:0]       dln_a   [NTASK];
  logic                due_a   [NTASK];

  assign ev = tick | done;

  function automatic logic [TW-1:0] tmin(input logic [TW-1:0] a, input logic [TW-1:0] b);
    return (a < b) ? a : b;
  endfunction

  vds_timebase #(.TW(TW)) u_time (.clk(clk), .rst_n(rst_n), .now(cur_time));

  // ---------------- per-task slots ----------------
  for (genvar g = 0; g < NTASK; g++) begin : g_slot
    vds_task_slot #(.TW(TW), .PW(PW)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cfg_we && (cfg_idx == IW'(g))),
      .ld_prio  (cfg_prio),
      .ld_period(cfg_period),
      .ld_rdl   (cfg_rdl),
      .ld_rel   (cfg_rel),
      .now      (cur_time),
      .complete (complete_v[g]),
      .upd      (ev),
      .nxt_state(nxt_a[g]),
      .en       (en_a[g]),
      .state    (st_a[g]),
      .prio     (prio_a[g]),
      .rel_nx   (reln_a[g]),
      .dl_nx    (dln_a[g]),
      .due      (due_a[g])
    );

    assign run_mask[g]   = en_a[g] && (st_a[g] == ST_RUN);
    assign complete_v[g] = done && run_mask[g];
    assign keep_v[g]     = run_mask[g] && !done;
    assign rdy_v[g]      = en_a[g] && ((st_a[g] == ST_READY) || due_a[g]);
    assign dorm_v[g]     = en_a[g] && ((st_a[g] == ST_DORM) || complete_v[g]) && !due_a[g];
    assign others_v[g]   = (rdy_v[g] && !(dispatch && best_idx == IW'(g))) ||
                           (keep_v[g] && preempt);

    always_comb begin
      if (dispatch && best_idx == IW'(g)) nxt_a[g] = ST_RUN;
      else if (keep_v[g])                 nxt_a[g] = preempt ? ST_READY : ST_RUN;
      else if (rdy_v[g])                  nxt_a[g] = ST_READY;
      else                                nxt_a[g] = ST_DORM;
    end
  end

  // ---------------- searches ----------------
  vds_argmin #(.N(NTASK), .KW(PW)) u_pick_ready (
    .vld(rdy_v), .key(prio_a), .any(best_any), .idx(best_idx), .kmin(best_prio)
  );

  vds_argmin #(.N(NTASK), .KW(PW)) u_pick_keep (
    .vld(keep_v), .key(prio_a), .any(keep_any), .idx(keep_idx), .kmin(keep_prio)
  );

  vds_argmin #(.N(NTASK), .KW(TW)) u_pick_dorm (
    .vld(dorm_v), .key(reln_a), .any(dmin_any), .idx(dmin_idx), .kmin(dmin_rel)
  );

  // ---------------- dispatch and mode ----------------
  assign preempt      = keep_any && best_any && (best_prio < keep_prio);
  assign dispatch     = best_any && (!keep_any || preempt);
  assign new_valid    = keep_any || dispatch;
  assign new_idx      = dispatch ? best_idx : keep_idx;
  assign others_ready = |others_v;
  assign run_dl       = dln_a[new_idx];
  assign vd_next      = (others_ready || !dmin_any) ? run_dl : tmin(run_dl, dmin_rel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_valid   <= 1'b0;
      run_idx     <= '0;
      mode_forced <= 1'b0;
      vdeadline   <= '0;
      power_down  <= 1'b0;
      wake_time   <= '0;
    end else if (ev) begin
      run_valid   <= new_valid;
      run_idx     <= new_valid ? new_idx : '0;
      mode_forced <= new_valid && others_ready;
      vdeadline   <= new_valid ? vd_next : '0;
      power_down  <= !new_valid;
      wake_time   <= new_valid ? '0 : (dmin_any ? dmin_rel : '1);
    end
  end
endmodule

// File: rtl/vds_chk.sv
module vds_chk #(
  parameter int N  = 8,
  parameter int TW = 16,
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ev,
  input logic [N-1:0]  run_mask,
  input logic          preempt,
  input logic [IW-1:0] best_idx,
  input logic          run_valid,
  input logic [IW-1:0] run_idx,
  input logic          mode_forced,
  input logic [TW-1:0] vdeadline,
  input logic          power_down,
  input logic [TW-1:0] wake_time
);
  AST_ONE_RUNNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(run_mask)); // R1

  AST_RUN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    run_valid |-> run_mask[run_idx]); // R1

  AST_IDLE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    power_down |-> !run_valid); // R8

  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ev |=> $stable({run_valid, run_idx, mode_forced, vdeadline, power_down, wake_time})); // R9

  AST_PREEMPT_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && preempt) |=> (run_valid && run_idx == $past(best_idx) && mode_forced)); // R4
endmodule

bind vdl_sched vds_chk #(.N(NTASK), .TW(TW), .IW(IW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ev         (ev),
  .run_mask   (run_mask),
  .preempt    (preempt),
  .best_idx   (best_idx),
  .run_valid  (run_valid),
  .run_idx    (run_idx),
  .mode_forced(mode_forced),
  .vdeadline  (vdeadline),
  .power_down (power_down),
  .wake_time  (wake_time)
);

// File: tb/vdl_sched_tb.sv
module vdl_sched_tb;
  localparam int NT = 8;
  localparam int TW = 16;
  localparam int PW = 3;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [PW-1:0] cfg_prio = '0;
  logic [TW-1:0] cfg_period = '0, cfg_rdl = '0, cfg_rel = '0;
  logic          tick = 1'b0, done = 1'b0;
  logic [TW-1:0] cur_time, vdeadline, wake_time;
  logic          run_valid, mode_forced, power_down;
  logic [IW-1:0] run_idx;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;
  logic [TW-1:0] B, Tc;

  always #5 clk = ~clk;

  vdl_sched #(.NTASK(NT), .TW(TW), .PW(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_prio(cfg_prio),
    .cfg_period(cfg_period), .cfg_rdl(cfg_rdl), .cfg_rel(cfg_rel), .tick(tick), .done(done),
    .cur_time(cur_time), .run_valid(run_valid), .run_idx(run_idx), .mode_forced(mode_forced),
    .vdeadline(vdeadline), .power_down(power_down), .wake_time(wake_time)
  );

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    finish_run();
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_out(input string req, input logic rv, input logic [IW-1:0] idx,
                           input logic mf, input logic [TW-1:0] vd, input logic pd,
                           input logic [TW-1:0] wk);
    check(req, {run_valid, run_idx, mode_forced, vdeadline, power_down, wake_time},
               {rv, idx, mf, vd, pd, wk});
  endtask

  task automatic load(input int idx, input int prio, input int per, input int rdl,
                      input logic [TW-1:0] rel);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_prio = PW'(prio);
    cfg_period = TW'(per); cfg_rdl = TW'(rdl); cfg_rel = rel;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic event_pulse(input logic t, input logic d);
    @(negedge clk);
    tick = t; done = d;
    @(negedge clk);
    tick = 1'b0; done = 1'b0;
  endtask

  task automatic wait_to(input logic [TW-1:0] t);
    while (cur_time < t) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    logic [TW-1:0] a;
    @(negedge clk);
    check_out("R10 reset outputs", 1'b0, '0, 1'b0, '0, 1'b0, '0);
    a = cur_time;
    @(negedge clk);
    check("R9 time counter step", 64'(cur_time), 64'(a + 16'd1));
  endtask

  task automatic t_empty();
    event_pulse(1'b1, 1'b0);
    check_out("R11 empty set wake all ones", 1'b0, '0, 1'b0, '0, 1'b1, 16'hFFFF);
  endtask

  task automatic t_load_and_release();
    B = cur_time;
    load(2, 3, 400, 300, B + 16'd50);
    load(5, 1, 1000, 500, B + 16'd150);
    load(0, 2, 1000, 200, B + 16'd600);
    load(4, 2, 2000, 300, B + 16'd600);
    event_pulse(1'b1, 1'b0);
    check_out("R2 R8 R10 nothing due yet, sleep to B+50", 1'b0, '0, 1'b0, '0, 1'b1, B + 16'd50);
    wait_to(B + 16'd50);
    event_pulse(1'b1, 1'b0);
    check_out("R2 R6 t2 runs, vdl clipped to B+150", 1'b1, 3'd2, 1'b0, B + 16'd150, 1'b0, '0);
  endtask

  task automatic t_preempt_and_complete();
    wait_to(B + 16'd150);
    event_pulse(1'b1, 1'b0);
    check_out("R4 R7 t5 preempts, forced", 1'b1, 3'd5, 1'b1, B + 16'd650, 1'b0, '0);
    event_pulse(1'b0, 1'b1);
    check_out("R5 R6 t2 resumes, own deadline", 1'b1, 3'd2, 1'b0, B + 16'd350, 1'b0, '0);
    event_pulse(1'b0, 1'b1);
    check_out("R5 R8 idle, t2 release advanced to B+450", 1'b0, '0, 1'b0, '0, 1'b1, B + 16'd450);
    event_pulse(1'b0, 1'b1);
    check_out("R5 done while idle ignored", 1'b0, '0, 1'b0, '0, 1'b1, B + 16'd450);
  endtask

  task automatic t_ties_and_equal();
    wait_to(B + 16'd450);
    event_pulse(1'b1, 1'b0);
    check_out("R6 t2 rerun, vdl B+600", 1'b1, 3'd2, 1'b0, B + 16'd600, 1'b0, '0);
    wait_to(B + 16'd600);
    event_pulse(1'b1, 1'b0);
    check_out("R3 R4 tie t0 over t4", 1'b1, 3'd0, 1'b1, B + 16'd800, 1'b0, '0);
    event_pulse(1'b0, 1'b1);
    check_out("R3 t4 over t2 by priority", 1'b1, 3'd4, 1'b1, B + 16'd900, 1'b0, '0);
    Tc = cur_time;
    load(7, 2, 5000, 100, Tc);
    event_pulse(1'b1, 1'b0);
    check_out("R4 equal priority t7 no preempt", 1'b1, 3'd4, 1'b1, B + 16'd900, 1'b0, '0);
    event_pulse(1'b0, 1'b1);
    check_out("R3 t7 priority beats lower index t2", 1'b1, 3'd7, 1'b1, Tc + 16'd100, 1'b0, '0);
    event_pulse(1'b0, 1'b1);
    check_out("R6 t2 alone, own deadline below dormant", 1'b1, 3'd2, 1'b0, B + 16'd750, 1'b0, '0);
    event_pulse(1'b0, 1'b1);
    check_out("R8 R1 idle, wake B+850", 1'b0, '0, 1'b0, '0, 1'b1, B + 16'd850);
  endtask

  task automatic t_hold();
    repeat (6) @(negedge clk);
    check_out("R9 outputs hold without events", 1'b0, '0, 1'b0, '0, 1'b1, B + 16'd850);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_empty();
    t_load_and_release();
    t_preempt_and_complete();
    t_ties_and_equal();
    t_hold();
    finish_run();
  end
endmodule